// File: doc/BRIEF.md
# Virtual Interrupt Flag Control Unit

This block decides what the clear-interrupt (CLI) and set-interrupt (STI) instructions do to the interrupt-related bits of the processor flags image. It also decides whether either instruction must take a general-protection fault instead. It keeps three bits in registers: the real interrupt enable (IF), the virtual interrupt enable (VIF) and the virtual interrupt pending bit (VIP). All other flag bits come from an input and pass through unchanged.

The choice between touching the real flag and touching the virtual shadow depends on three inputs: the protected-mode virtual interrupt enable from the control register, the current privilege level, and the I/O privilege level. Virtual mode is active only when the enable is set, the current privilege level is 3 and the I/O privilege level is below 3.

A fault handler reloads VIF and VIP through a small write port. A separate interrupt-arrival input tells the block about an incoming vector. The block then reports whether that vector should be taken now, or records it as pending in VIP.

Top module: `vifc_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, IF, VIF and VIP read 0, and `gp_fault_o` and `irq_take_o` are low.
- R2: `eflags_o` carries IF at bit 9, VIF at bit 19 and VIP at bit 20. Every other bit equals the same bit of `eflags_i`.
- R3: Virtual mode is active when `pvi_en`=1, `cpl`=3 and `iopl`<3. In virtual mode a strobe with `ins_sti`=0 (CLI) clears VIF, and a strobe with `ins_sti`=1 (STI) sets VIF. IF is left unchanged. The result shows on the cycle after the strobe.
- R4: In virtual mode, an STI issued while VIP=1 raises a fault, and IF, VIF and VIP keep their values.
- R5: Outside virtual mode, a CLI or STI with `cpl` numerically greater than `iopl` raises a fault, and IF and VIF keep their values.
- R6: Outside virtual mode with `cpl` <= `iopl` (this includes every case with `iopl`=3), CLI clears IF and STI sets IF. VIF and VIP are unchanged.
- R7: `gp_fault_o` is high for exactly the one cycle that follows a faulting strobe. It is never high without a strobe on the cycle before.
- R8: When `wr_en`=1, VIF and VIP take `wr_vif` and `wr_vip` on the next cycle. The write overrides any instruction or interrupt effect on those two bits in that cycle.
- R9: An arriving vector below 32 (an exception or NMI) is always taken: `irq_take_o` is high on the next cycle and VIP is not changed.
- R10: In virtual mode, an arriving vector from 32 to 255 is taken if VIF=1. If VIF=0 it is not taken and VIP is set.
- R11: Outside virtual mode, an arriving vector from 32 to 255 is taken exactly when IF=1. VIF is not consulted and VIP is not changed, so VIP is never set while `cpl` is below 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_vld | input | 1 | One-cycle instruction strobe |
| ins_sti | input | 1 | 1 selects STI, 0 selects CLI |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| pvi_en | input | 1 | Protected-mode virtual interrupt enable |
| wr_en | input | 1 | Handler write strobe for VIF and VIP |
| wr_vif | input | 1 | VIF value to load |
| wr_vip | input | 1 | VIP value to load |
| int_vld | input | 1 | Interrupt arrival strobe |
| int_vec | input | 8 | Arriving interrupt vector |
| eflags_i | input | 32 | Flag image supplying the untouched bits |
| eflags_o | output | 32 | Flag image with IF, VIF and VIP merged in |
| gp_fault_o | output | 1 | General-protection fault pulse |
| irq_take_o | output | 1 | Arriving vector should be taken now |

## Verification
The hardest state to reach is a virtual-mode STI while VIP is already set, because VIP only becomes 1 through the write port or through a maskable vector that arrives while VIF is clear. The bench reaches it by building every IF/VIF/VIP starting combination before each instruction. It sets IF with a privileged STI or CLI at I/O privilege level 3, then loads VIF and VIP through the write port. It then sweeps all privilege, I/O privilege, enable and CLI/STI combinations from each of those starting states.

// File: rtl/vifc_pkg.sv
package vifc_pkg;
    parameter int FLAG_W     = 32;
    parameter int IF_POS     = 9;
    parameter int VIF_POS    = 19;
    parameter int VIP_POS    = 20;
    parameter int VEC_W      = 8;
    parameter int PL_W       = 2;
    parameter int MASK_FIRST = 32;

    typedef struct packed {
        logic if_f;
        logic vif;
        logic vip;
        logic fault;
        logic take;
    } vifc_state_t;

    typedef struct packed {
        logic virt;
        logic fault;
        logic upd_if;
        logic if_val;
        logic upd_vif;
        logic vif_val;
    } vifc_act_t;
endpackage

// File: rtl/vifc_ins_dec.sv
module vifc_ins_dec
    import vifc_pkg::*;
#(
    parameter int P_W = PL_W
) (
    input  logic           ins_vld,
    input  logic           ins_sti,
    input  logic [P_W-1:0] cpl,
    input  logic [P_W-1:0] iopl,
    input  logic           pvi_en,
    input  logic           vip_cur,
    output vifc_act_t      act
);
    localparam logic [P_W-1:0] USER_PL = {P_W{1'b1}};

    always_comb begin
        act         = '0;
        act.virt    = pvi_en && (cpl == USER_PL) && (iopl != USER_PL);
        if (ins_vld) begin
            if (act.virt) begin
                if (ins_sti && vip_cur) begin
                    act.fault = 1'b1;
                end else begin
                    act.upd_vif = 1'b1;
                    act.vif_val = ins_sti;
                end
            end else if (cpl > iopl) begin
                act.fault = 1'b1;
            end else begin
                act.upd_if = 1'b1;
                act.if_val = ins_sti;
            end
        end
    end
endmodule

// File: rtl/vifc_irq_gate.sv
module vifc_irq_gate
    import vifc_pkg::*;
#(
    parameter int V_W   = VEC_W,
    parameter int FIRST = MASK_FIRST
) (
    input  logic           int_vld,
    input  logic [V_W-1:0] int_vec,
    input  logic           virt,
    input  logic           if_cur,
    input  logic           vif_cur,
    output logic           take,
    output logic           set_pend
);
    localparam logic [V_W-1:0] FIRST_V = V_W'(FIRST);

    logic maskable;

    always_comb begin
        maskable = int_vec >= FIRST_V;
        take     = 1'b0;
        set_pend = 1'b0;
        if (int_vld) begin
            if (!maskable) begin
                take = 1'b1;
            end else if (virt) begin
                take     = vif_cur;
                set_pend = !vif_cur;
            end else begin
                take = if_cur;
            end
        end
    end
endmodule

// File: rtl/vifc_flag_merge.sv
module vifc_flag_merge
    import vifc_pkg::*;
#(
    parameter int W  = FLAG_W,
    parameter int PI = IF_POS,
    parameter int PV = VIF_POS,
    parameter int PP = VIP_POS
) (
    input  logic [W-1:0] img_i,
    input  logic         if_f,
    input  logic         vif,
    input  logic         vip,
    output logic [W-1:0] img_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == PI) begin : g_if
            assign img_o[b] = if_f;
        end else if (b == PV) begin : g_vif
            assign img_o[b] = vif;
        end else if (b == PP) begin : g_vip
            assign img_o[b] = vip;
        end else begin : g_pass
            assign img_o[b] = img_i[b];
        end
    end
endmodule

// File: rtl/vifc_top.sv
module vifc_top
    import vifc_pkg::*;
#(
    parameter int W   = FLAG_W,
    parameter int V_W = VEC_W,
    parameter int P_W = PL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_vld,
    input  logic           ins_sti,
    input  logic [P_W-1:0] cpl,
    input  logic [P_W-1:0] iopl,
    input  logic           pvi_en,
    input  logic           wr_en,
    input  logic           wr_vif,
    input  logic           wr_vip,
    input  logic           int_vld,
    input  logic [V_W-1:0] int_vec,
    input  logic [W-1:0]   eflags_i,
    output logic [W-1:0]   eflags_o,
    output logic           gp_fault_o,
    output logic           irq_take_o
);
    localparam logic [P_W-1:0] USER_PL = {P_W{1'b1}};
    localparam logic [V_W-1:0] FIRST_V = V_W'(MASK_FIRST);

    vifc_state_t st_d, st_q;
    vifc_act_t   act;
    logic        take, set_pend;

    vifc_ins_dec #(.P_W(P_W)) u_dec (
        .ins_vld (ins_vld),
        .ins_sti (ins_sti),
        .cpl     (cpl),
        .iopl    (iopl),
        .pvi_en  (pvi_en),
        .vip_cur (st_q.vip),
        .act     (act)
    );

    vifc_irq_gate #(.V_W(V_W), .FIRST(MASK_FIRST)) u_gate (
        .int_vld  (int_vld),
        .int_vec  (int_vec),
        .virt     (act.virt),
        .if_cur   (st_q.if_f),
        .vif_cur  (st_q.vif),
        .take     (take),
        .set_pend (set_pend)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fault = act.fault;
        st_d.take  = take;
        if (act.upd_if) begin
            st_d.if_f = act.if_val;
        end
        if (act.upd_vif) begin
            st_d.vif = act.vif_val;
        end
        if (set_pend) begin
            st_d.vip = 1'b1;
        end
        if (wr_en) begin
            st_d.vif = wr_vif;
            st_d.vip = wr_vip;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    vifc_flag_merge #(.W(W), .PI(IF_POS), .PV(VIF_POS), .PP(VIP_POS)) u_merge (
        .img_i (eflags_i),
        .if_f  (st_q.if_f),
        .vif   (st_q.vif),
        .vip   (st_q.vip),
        .img_o (eflags_o)
    );

    assign gp_fault_o = st_q.fault;
    assign irq_take_o = st_q.take;

    AST_FAULT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault_o |-> $past(ins_vld)); // R7
    AST_FAULT_KEEPS_IF: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault_o |-> (eflags_o[IF_POS] == $past(eflags_o[IF_POS]))); // R5
    AST_FAULT_KEEPS_VIF: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_fault_o && !$past(wr_en)) |-> (eflags_o[VIF_POS] == $past(eflags_o[VIF_POS]))); // R4
    AST_VIRT_IF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && pvi_en && cpl == USER_PL && iopl != USER_PL) |=> $stable(st_q.if_f)); // R3
    AST_EXC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (int_vld && int_vec < FIRST_V) |=> irq_take_o); // R9
    AST_LOW_CPL_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl != USER_PL && !wr_en && !st_q.vip) |=> !st_q.vip); // R11
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.vif == $past(wr_vif) && st_q.vip == $past(wr_vip))); // R8
endmodule

// File: tb/sim_vifc_top.sv
module sim_vifc_top;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_vld = 1'b0, ins_sti = 1'b0;
    logic [1:0]  cpl = 2'd0, iopl = 2'd0;
    logic        pvi_en = 1'b0;
    logic        wr_en = 1'b0, wr_vif = 1'b0, wr_vip = 1'b0;
    logic        int_vld = 1'b0;
    logic [7:0]  int_vec = 8'd0;
    logic [31:0] eflags_i = 32'h0;
    logic [31:0] eflags_o;
    logic        gp_fault_o, irq_take_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic m_if, m_vif, m_vip;

    always #(CLK_PER/2) clk = ~clk;

    vifc_top u0 (
        .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_sti(ins_sti),
        .cpl(cpl), .iopl(iopl), .pvi_en(pvi_en), .wr_en(wr_en),
        .wr_vif(wr_vif), .wr_vip(wr_vip), .int_vld(int_vld), .int_vec(int_vec),
        .eflags_i(eflags_i), .eflags_o(eflags_o), .gp_fault_o(gp_fault_o),
        .irq_take_o(irq_take_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_img(input logic [31:0] src);
        logic [31:0] r;
        r = src;
        r[9] = m_if; r[19] = m_vif; r[20] = m_vip;
        return r;
    endfunction

    task automatic ins(input logic sti, input logic [1:0] c, input logic [1:0] io, input logic p);
        ins_vld = 1'b1; ins_sti = sti; cpl = c; iopl = io; pvi_en = p;
        @(negedge clk);
        ins_vld = 1'b0;
    endtask

    task automatic wr(input logic v, input logic p);
        wr_en = 1'b1; wr_vif = v; wr_vip = p;
        @(negedge clk);
        wr_en = 1'b0;
        m_vif = v; m_vip = p;
    endtask

    task automatic set_state(input logic i, input logic v, input logic p);
        ins(i, 2'd0, 2'd3, 1'b0);
        m_if = i;
        wr(v, p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_if = 0; m_vif = 0; m_vip = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset flags", eflags_o, 32'h0);
        chk("R1 reset fault", {31'd0, gp_fault_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset flags", eflags_o, 32'h0);
        chk("R1 after reset take", {31'd0, irq_take_o}, 32'd0);

        // R2 passthrough patterns
        foreach (m_pat[k]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pat;
            pat = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0 : (k == 2) ? 32'hA5A5_5A5A : 32'h1234_5678;
            set_state(k[0], k[1], ~k[0]);
            eflags_i = pat;
            #1;
            chk("R2 image merge", eflags_o, exp_img(pat));
        end
        eflags_i = 32'h0;

        // R3..R7 exhaustive sweep
        for (int c = 0; c < 4; c++) begin
            for (int io = 0; io < 4; io++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int s = 0; s < 2; s++) begin
                        for (int st = 0; st < 8; st++) begin
                            bit virt, flt;
                            string tag;
                            set_state(st[2], st[1], st[0]);
                            virt = (p == 1) && (c == 3) && (io < 3);
                            flt = 0;
                            if (virt) begin
                                if (s == 1 && m_vip) begin flt = 1; tag = "R4 virt STI pending"; end
                                else begin m_vif = s[0]; tag = "R3 virt CLI/STI"; end
                            end else if (c > io) begin
                                flt = 1; tag = "R5 privilege fault";
                            end else begin
                                m_if = s[0]; tag = "R6 real CLI/STI";
                            end
                            ins(s[0], c[1:0], io[1:0], p[0]);
                            chk(tag, eflags_o, exp_img(32'h0));
                            chk("R7 fault pulse", {31'd0, gp_fault_o}, {31'd0, flt});
                            @(negedge clk);
                            chk("R7 fault one cycle", {31'd0, gp_fault_o}, 32'd0);
                        end
                    end
                end
            end
        end

        // R9..R11 interrupt sweep
        for (int md = 0; md < 3; md++) begin
            for (int st = 0; st < 4; st++) begin
                for (int vi = 0; vi < 7; vi++) begin
                    logic [7:0] v;
                    bit virt, exp_take;
                    v = (vi == 0) ? 8'd0 : (vi == 1) ? 8'd2 : (vi == 2) ? 8'd31 :
                        (vi == 3) ? 8'd32 : (vi == 4) ? 8'd33 : (vi == 5) ? 8'd128 : 8'd255;
                    set_state(st[1], st[0], 1'b0);
                    cpl    = (md == 1) ? 2'd0 : 2'd3;
                    iopl   = (md == 2) ? 2'd3 : 2'd0;
                    pvi_en = (md != 1);
                    virt   = (md == 0);
                    if (v < 32) exp_take = 1;
                    else if (virt) begin exp_take = m_vif; if (!m_vif) m_vip = 1; end
                    else exp_take = m_if;
                    int_vld = 1'b1; int_vec = v;
                    @(negedge clk);
                    int_vld = 1'b0;
                    if (v < 32) chk("R9 exception taken", {31'd0, irq_take_o}, {31'd0, exp_take});
                    else if (virt) chk("R10 virt maskable", {31'd0, irq_take_o}, {31'd0, exp_take});
                    else chk("R11 real maskable", {31'd0, irq_take_o}, {31'd0, exp_take});
                    chk("R10 R11 pending bit", eflags_o, exp_img(32'h0));
                end
            end
        end

        // R8 write priority over instruction and interrupt
        set_state(1'b0, 1'b0, 1'b0);
        ins_vld = 1'b1; ins_sti = 1'b1; cpl = 2'd3; iopl = 2'd0; pvi_en = 1'b1;
        int_vld = 1'b1; int_vec = 8'd64;
        wr_en = 1'b1; wr_vif = 1'b0; wr_vip = 1'b0;
        @(negedge clk);
        ins_vld = 1'b0; int_vld = 1'b0; wr_en = 1'b0;
        chk("R8 write priority", eflags_o, exp_img(32'h0));
        wr(1'b1, 1'b1);
        chk("R8 write load", eflags_o, exp_img(32'h0));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    int m_pat[1];
endmodule